// File: doc/BRIEF.md
# Multi-Mode Operand Addressing Unit

This unit carries out one two-operand add, `Rd <- Rd + source`, per request. The source operand is found by one of ten addressing modes. Some modes take it straight from a register or from the request's constant. Others read it from a data memory port at an address the unit computes. Memory-indirect mode makes two dependent reads. The two auto-step modes adjust the base register by the operand size after the access. The unit holds its own register file of eight 32-bit registers. All of them are visible on one flat output bus.

A request is presented with `start` while the unit is idle. It carries a mode code, a destination register, base and index register numbers, a 32-bit constant and a size code. The unit stays busy until it has written the result. It then pulses `done` for one cycle. An illegal mode code ends the request with the `illegal` flag and no change of any state. The memory port returns read data one cycle after the read strobe. Memory is addressed with the byte address the unit computes.

Top module: `opaddr_unit`

## Requirements
- R1: While and right after the synchronous active-high reset, all eight registers read zero, and `busy`, `done`, `illegal` and `mem_rd_en` are low.
- R2: Mode 0 (register direct) adds the register selected by `rb` to `Rd`. Mode 1 (immediate) adds `imm` to `Rd`. Neither mode reads memory, and `done` is high in the 2nd cycle after the edge that accepts `start`.
- R3: Mode 2 reads memory at `imm + Rb`. Mode 3 reads at `Rb`. Mode 4 reads at `Rb + Rx`. Mode 5 reads at `imm`. Each mode performs exactly one read, adds the data to `Rd`, and raises `done` in the 3rd cycle after acceptance.
- R4: Mode 6 (memory indirect) reads memory at `Rb`, then reads again at the address returned by that first read, and adds the second read's data to `Rd`. It makes exactly two reads, and `done` is high in the 4th cycle.
- R5: Mode 7 reads memory at `Rb`, adds the data to `Rd`, and increases `Rb` by d. Mode 8 does the same but decreases `Rb` by d. Both use the base value before the step as the address, and both take one read and 3 cycles.
- R6: Mode 9 (scaled) reads memory at `imm + Rb + Rx*d` and adds the data to `Rd`. It takes one read and 3 cycles.
- R7: `size` encodes d as 1, 2, 4 or 8 for codes 0, 1, 2 and 3.
- R8: Mode codes 10 to 15 are illegal. Such a request raises `illegal` together with `done` in the 2nd cycle, makes no memory read, and changes no register.
- R9: In modes 7 and 8, when `rd` equals `rb`, the register ends up holding the sum, and the base step is discarded.
- R10: Read data is taken from `mem_rdata` one cycle after `mem_rd_en`. `mem_rd_en` is high for exactly one cycle per read, and only while busy.
- R11: `start` is ignored while `busy` is high. Request fields are captured only at acceptance.
- R12: `done` is a single-cycle pulse. `illegal` is high only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| mode | input | 4 | Addressing mode code (0..9 legal) |
| rd | input | 3 | Destination register number |
| rb | input | 3 | Base register (source register in mode 0) |
| rx | input | 3 | Index register number |
| imm | input | 32 | Constant: immediate, displacement or absolute address |
| size | input | 2 | Operand size code, d = 1 << size |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the strobe |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion of a request with an illegal mode |
| regs_flat | output | 256 | Register file, register i at bits [32*i+31:32*i] |

## Verification
Counting from the clock edge that accepts `start`, `done` is due in the 2nd cycle for register, immediate and illegal requests. It is due in the 3rd cycle for the single-read modes and in the 4th for memory indirect. The register file already holds the new values in the cycle where `done` is high. The bench drives each request half a cycle before an edge. It then samples on every falling edge and records the first one with `done` high. That count is compared with the expected one for the mode. The register file is compared against a bench model in that same cycle, and `done` must be low again one cycle later. A counter of read strobes gives the per-request read count. The bench memory returns a computed function of the address one cycle after each strobe. A wrong address or a wrong read order therefore shows up as a wrong sum.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    localparam int DEF_XLEN = 32;
    localparam int DEF_NREG = 8;
    localparam int MODE_W   = 4;
    localparam int SIZE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_REG    = 4'd0,
        AM_IMM    = 4'd1,
        AM_DISP   = 4'd2,
        AM_RIND   = 4'd3,
        AM_IDX    = 4'd4,
        AM_ABS    = 4'd5,
        AM_MIND   = 4'd6,
        AM_AINC   = 4'd7,
        AM_ADEC   = 4'd8,
        AM_SCALED = 4'd9
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP,
        ST_RD1,
        ST_RD2,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic base_wr;
        logic done;
        logic illegal;
    } ctl_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return m <= AM_SCALED;
    endfunction

    function automatic logic mode_uses_mem(input logic [MODE_W-1:0] m);
        return mode_legal(m) && (m != AM_REG) && (m != AM_IMM);
    endfunction

    function automatic logic mode_steps_base(input logic [MODE_W-1:0] m);
        return (m == AM_AINC) || (m == AM_ADEC);
    endfunction

endpackage

// File: rtl/opaddr_regfile.sv
module opaddr_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RIDX-1:0]      ra_dst,
    input  logic [RIDX-1:0]      ra_base,
    input  logic [RIDX-1:0]      ra_idx,
    output logic [XLEN-1:0]      rv_dst,
    output logic [XLEN-1:0]      rv_base,
    output logic [XLEN-1:0]      rv_idx,
    input  logic                 we_dst,
    input  logic [RIDX-1:0]      wa_dst,
    input  logic [XLEN-1:0]      wd_dst,
    input  logic                 we_base,
    input  logic [RIDX-1:0]      wa_base,
    input  logic [XLEN-1:0]      wd_base,
    output logic [NREG*XLEN-1:0] regs_flat
);

    logic [NREG-1:0][XLEN-1:0] rf;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [RIDX-1:0] IDX = RIDX'(i);
        logic [XLEN-1:0] q;
        // destination write has priority over the base step
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we_dst && (wa_dst == IDX)) begin
                q <= wd_dst;
            end else if (we_base && (wa_base == IDX)) begin
                q <= wd_base;
            end
        end
        assign rf[i] = q;
    end

    assign rv_dst    = rf[ra_dst];
    assign rv_base   = rf[ra_base];
    assign rv_idx    = rf[ra_idx];
    assign regs_flat = rf;

endmodule

// File: rtl/opaddr_agen.sv
module opaddr_agen
    import opaddr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [XLEN-1:0]   imm,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   idx_val,
    input  logic [SIZE_W-1:0] size_code,
    output logic [XLEN-1:0]   eff_addr,
    output logic [XLEN-1:0]   direct_src
);

    logic [XLEN-1:0] idx_scaled;

    assign idx_scaled = idx_val << size_code;

    always_comb begin
        case (mode)
            AM_DISP:   eff_addr = imm + base_val;
            AM_RIND,
            AM_MIND,
            AM_AINC,
            AM_ADEC:   eff_addr = base_val;
            AM_IDX:    eff_addr = base_val + idx_val;
            AM_ABS:    eff_addr = imm;
            AM_SCALED: eff_addr = imm + base_val + idx_scaled;
            default:   eff_addr = '0;
        endcase
    end

    assign direct_src = (mode == AM_REG) ? base_val : imm;

endmodule

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
    import opaddr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RIDX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [RIDX-1:0]   rd,
    input  logic [RIDX-1:0]   rb,
    input  logic [RIDX-1:0]   rx,
    input  logic [XLEN-1:0]   imm,
    input  logic [SIZE_W-1:0] size_code,
    output logic [MODE_W-1:0] cap_mode,
    output logic [RIDX-1:0]   cap_rd,
    output logic [RIDX-1:0]   cap_rb,
    output logic [RIDX-1:0]   cap_rx,
    output logic [XLEN-1:0]   cap_imm,
    output logic [SIZE_W-1:0] cap_size,
    input  logic [XLEN-1:0]   dst_val,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   eff_addr,
    input  logic [XLEN-1:0]   direct_src,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   base_data,
    output ctl_t              ctl,
    output logic              busy
);

    state_e          st_q, st_d;
    logic            ill_q;
    logic [XLEN-1:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ill_q    <= 1'b0;
            cap_mode <= '0;
            cap_rd   <= '0;
            cap_rb   <= '0;
            cap_rx   <= '0;
            cap_imm  <= '0;
            cap_size <= '0;
        end else begin
            st_q <= st_d;
            if ((st_q == ST_IDLE) && start) begin
                ill_q    <= !mode_legal(mode);
                cap_mode <= mode;
                cap_rd   <= rd;
                cap_rb   <= rb;
                cap_rx   <= rx;
                cap_imm  <= imm;
                cap_size <= size_code;
            end
        end
    end

    assign step = XLEN'(1) << cap_size;

    always_comb begin
        st_d      = st_q;
        ctl       = '0;
        mem_addr  = eff_addr;
        wr_data   = dst_val + mem_rdata;
        base_data = (cap_mode == AM_AINC) ? base_val + step : base_val - step;
        case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_OP;
            end
            ST_OP: begin
                if (ill_q) begin
                    st_d = ST_FIN;
                end else if (!mode_uses_mem(cap_mode)) begin
                    ctl.wr_en = 1'b1;
                    wr_data   = dst_val + direct_src;
                    st_d      = ST_FIN;
                end else begin
                    ctl.rd_en = 1'b1;
                    st_d      = ST_RD1;
                end
            end
            ST_RD1: begin
                if (cap_mode == AM_MIND) begin
                    ctl.rd_en = 1'b1;
                    mem_addr  = mem_rdata;
                    st_d      = ST_RD2;
                end else begin
                    ctl.wr_en   = 1'b1;
                    ctl.base_wr = mode_steps_base(cap_mode);
                    st_d        = ST_FIN;
                end
            end
            ST_RD2: begin
                ctl.wr_en = 1'b1;
                st_d      = ST_FIN;
            end
            ST_FIN: begin
                ctl.done    = 1'b1;
                ctl.illegal = ill_q;
                st_d        = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
    import opaddr_pkg::*;
#(
    parameter int XLEN = DEF_XLEN,
    parameter int NREG = DEF_NREG,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [MODE_W-1:0]    mode,
    input  logic [RIDX-1:0]      rd,
    input  logic [RIDX-1:0]      rb,
    input  logic [RIDX-1:0]      rx,
    input  logic [XLEN-1:0]      imm,
    input  logic [SIZE_W-1:0]    size,
    output logic                 mem_rd_en,
    output logic [XLEN-1:0]      mem_addr,
    input  logic [XLEN-1:0]      mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 illegal,
    output logic [NREG*XLEN-1:0] regs_flat
);

    logic [MODE_W-1:0] cap_mode;
    logic [RIDX-1:0]   cap_rd, cap_rb, cap_rx;
    logic [XLEN-1:0]   cap_imm;
    logic [SIZE_W-1:0] cap_size;
    logic [XLEN-1:0]   dst_val, base_val, idx_val;
    logic [XLEN-1:0]   eff_addr, direct_src, wr_data, base_data;
    ctl_t              ctl;

    opaddr_ctrl #(.XLEN(XLEN), .RIDX(RIDX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode       (mode),
        .rd         (rd),
        .rb         (rb),
        .rx         (rx),
        .imm        (imm),
        .size_code  (size),
        .cap_mode   (cap_mode),
        .cap_rd     (cap_rd),
        .cap_rb     (cap_rb),
        .cap_rx     (cap_rx),
        .cap_imm    (cap_imm),
        .cap_size   (cap_size),
        .dst_val    (dst_val),
        .base_val   (base_val),
        .eff_addr   (eff_addr),
        .direct_src (direct_src),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .wr_data    (wr_data),
        .base_data  (base_data),
        .ctl        (ctl),
        .busy       (busy)
    );

    opaddr_agen #(.XLEN(XLEN)) u_agen (
        .mode       (cap_mode),
        .imm        (cap_imm),
        .base_val   (base_val),
        .idx_val    (idx_val),
        .size_code  (cap_size),
        .eff_addr   (eff_addr),
        .direct_src (direct_src)
    );

    opaddr_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .ra_dst    (cap_rd),
        .ra_base   (cap_rb),
        .ra_idx    (cap_rx),
        .rv_dst    (dst_val),
        .rv_base   (base_val),
        .rv_idx    (idx_val),
        .we_dst    (ctl.wr_en),
        .wa_dst    (cap_rd),
        .wd_dst    (wr_data),
        .we_base   (ctl.base_wr),
        .wa_base   (cap_rb),
        .wd_base   (base_data),
        .regs_flat (regs_flat)
    );

    assign mem_rd_en = ctl.rd_en;
    assign done      = ctl.done;
    assign illegal   = ctl.illegal;

endmodule

// File: rtl/opaddr_unit_chk.sv
module opaddr_unit_chk #(
    parameter int XLEN = 32,
    parameter int NREG = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 illegal,
    input logic                 mem_rd_en,
    input logic [NREG*XLEN-1:0] regs_flat
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (regs_flat == '0 && !busy && !done && !mem_rd_en)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12

    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done); // R12

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(regs_flat)); // R8

    AST_ILLEGAL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !$past(mem_rd_en)); // R8

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy); // R10

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done)); // R11

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R11

endmodule

bind opaddr_unit opaddr_unit_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_rd_en (mem_rd_en),
    .regs_flat (regs_flat)
);

// File: tb/test_opaddr_unit.sv
`timescale 1ns/1ps
module test_opaddr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  rd = '0, rb = '0, rx = '0;
    logic [31:0] imm = '0;
    logic [1:0]  size = '0;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, illegal;
    logic [255:0] regs_flat;

    int checks = 0;
    int failures = 0;
    int reads_seen = 0;
    logic [31:0] model [8];

    always #2 clk = ~clk;

    opaddr_unit i_opaddr_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .rd(rd), .rb(rb),
        .rx(rx), .imm(imm), .size(size), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .illegal(illegal), .regs_flat(regs_flat)
    );

    function automatic logic [31:0] mval(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    // memory with one-cycle read latency (R10)
    always @(posedge clk) begin
        mem_rdata <= mval(mem_addr);
        if (mem_rd_en) reads_seen <= reads_seen + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        for (int i = 0; i < 8; i++)
            chk(regs_flat[i*32 +: 32] == model[i], tag, $sformatf("reg%0d", i),
                regs_flat[i*32 +: 32], model[i]);
    endtask

    function automatic string mode_tag(input int m, input int rdi, input int rbi);
        if (m > 9) return "R8";
        if ((m == 7 || m == 8) && rdi == rbi) return "R9";
        case (m)
            0, 1: return "R2";
            6:    return "R4";
            7, 8: return "R5";
            9:    return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic run_op(input int m, input int rdi, input int rbi, input int rxi,
                          input logic [31:0] iv, input int szc, input bit hold,
                          input string tag_in);
        logic [31:0] d, rdv, rbv, rxv, src;
        int exp_lat, exp_reads, lat;
        bit ill_seen;
        string tag;
        tag = (tag_in == "") ? mode_tag(m, rdi, rbi) : tag_in;
        d = 32'd1 << szc;
        rdv = model[rdi]; rbv = model[rbi]; rxv = model[rxi];
        case (m)
            0: src = rbv;
            1: src = iv;
            2: src = mval(iv + rbv);
            3, 7, 8: src = mval(rbv);
            4: src = mval(rbv + rxv);
            5: src = mval(iv);
            6: src = mval(mval(rbv));
            9: src = mval(iv + rbv + rxv * d);
            default: src = '0;
        endcase
        exp_lat   = (m > 9 || m < 2) ? 2 : (m == 6 ? 4 : 3);
        exp_reads = (m > 9 || m < 2) ? 0 : (m == 6 ? 2 : 1);
        if (m == 7) model[rbi] = rbv + d;
        if (m == 8) model[rbi] = rbv - d;
        if (m <= 9) model[rdi] = rdv + src;   // sum written last (R9)

        @(negedge clk);
        mode = 4'(m); rd = 3'(rdi); rb = 3'(rbi); rx = 3'(rxi);
        imm = iv; size = 2'(szc); start = 1'b1;
        reads_seen = 0;
        lat = 0; ill_seen = 1'b0;
        for (int k = 1; k <= 10 && lat == 0; k++) begin
            @(negedge clk);
            if (k == 1 && hold) begin
                // new fields while busy must be ignored (R11)
                mode = 4'd15; rd = ~rd; rb = ~rb; imm = ~imm; size = ~size;
            end else begin
                start = 1'b0;
            end
            if (done) begin lat = k; ill_seen = illegal; end
        end
        start = 1'b0;
        chk(lat == exp_lat, tag, "done latency", 32'(lat), 32'(exp_lat));
        chk(reads_seen == exp_reads, tag, "read count R10", 32'(reads_seen), 32'(exp_reads));
        chk(ill_seen == (m > 9), tag, "illegal flag", 32'(ill_seen), 32'(m > 9));
        chk_regs(tag);
        @(negedge clk);
        chk(!done && !illegal, "R12", "done pulse width", {30'd0, done, illegal}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int m;
        for (int i = 0; i < 8; i++) model[i] = '0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !illegal && !mem_rd_en, "R1", "control outputs",
            {28'd0, busy, done, illegal, mem_rd_en}, 32'd0);
        chk_regs("R1");

        // R2: load registers through immediate adds, then register direct
        for (int r = 0; r < 8; r++) run_op(1, r, 0, 0, 32'h100 * (r + 1) + 32'(r), 0, 0, "R2");
        run_op(0, 2, 5, 0, 32'hFFFF_FFFF, 0, 0, "R2");
        run_op(0, 3, 3, 0, 32'h0, 0, 0, "R2");
        // R3: single-read modes
        run_op(2, 1, 4, 0, 32'h40, 0, 0, "R3");
        run_op(3, 6, 7, 0, 32'h0, 0, 0, "R3");
        run_op(4, 0, 2, 5, 32'h0, 0, 0, "R3");
        run_op(5, 7, 0, 0, 32'hDEAD_BEE0, 0, 0, "R3");
        // R4: memory indirect
        run_op(6, 4, 1, 0, 32'h0, 0, 0, "R4");
        // R5: auto increment / decrement
        run_op(7, 2, 6, 0, 32'h0, 2, 0, "R5");
        run_op(8, 3, 5, 0, 32'h0, 3, 0, "R5");
        run_op(8, 3, 0, 0, 32'h0, 0, 0, "R5");
        // R6 / R7: scaled with every size code
        for (int s = 0; s < 4; s++) run_op(9, 5, 1, 3, 32'h20, s, 0, "R7");
        run_op(7, 1, 2, 0, 32'h0, 1, 0, "R7");
        run_op(9, 0, 7, 7, 32'hFFFF_FFF0, 3, 0, "R6");
        // R9: destination equals auto-stepped base
        run_op(7, 4, 4, 0, 32'h0, 2, 0, "R9");
        run_op(8, 6, 6, 0, 32'h0, 3, 0, "R9");
        // R8: illegal codes
        run_op(10, 1, 2, 3, 32'h55, 1, 0, "R8");
        run_op(15, 0, 0, 0, 32'hAA, 3, 0, "R8");
        // R11: start held and fields changed while busy
        run_op(1, 5, 0, 0, 32'h77, 0, 1, "R11");
        run_op(6, 2, 3, 0, 32'h0, 0, 1, "R11");

        // random mix
        for (int n = 0; n < 150; n++) begin
            m = $urandom % 12;
            if (m >= 10) m = 10 + ($urandom % 6);
            run_op(m, $urandom % 8, $urandom % 8, $urandom % 8, $urandom,
                   $urandom % 4, ($urandom % 8) == 0, "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule